// File: doc/BRIEF.md
# Channel-Tagged Conversion Result Queue

This block buffers finished analog-to-digital conversion results on a priority conversion path. Each time a conversion completes, the converter side pulses a write strobe with a 12-bit result and the 5-bit number of the input channel that produced it. The block stores the two together as one entry. It holds up to four entries. Software drains them oldest first by repeated reads of one 32-bit read port.

A 2-bit threshold register selects how many held entries raise an interrupt request flag. The flag stays set until software clears it. It rises again only after the fill level has dropped below the threshold and then reached it again. A write into a full queue is discarded and sets a sticky overrun flag. Channel numbers that the configured device does not have are not recorded: their tag field reads as zero.

The block has two state machines. The occupancy machine has the states Q_EMPTY, Q_PART and Q_FULL. Its transitions are fill (Q_EMPTY to Q_PART, or to Q_FULL when the depth is 1), top-off (Q_PART to Q_FULL), drain (Q_PART to Q_EMPTY), and release (Q_FULL to Q_PART, or to Q_EMPTY when the depth is 1). A state holds when pushes and pops balance. The interrupt machine has the states I_WAIT, I_RAISED and I_SPENT. Its transitions are raise (I_WAIT to I_RAISED when the next fill level meets the threshold), ack-low (I_RAISED to I_WAIT on a clear while the level is below the threshold), ack-high (I_RAISED to I_SPENT on a clear while the level still meets the threshold), and rearm (I_SPENT to I_WAIT when the level falls below the threshold).

Top module: `conv_result_queue`

## Requirements
- R1: The queue holds at most four entries. Successive reads return the stored entries in the order they were written, oldest first.
- R2: The read word carries the 12-bit result in bits 31:20, with the result MSB at bit 31. Bits 19:5 read as zero. Bits 4:0 carry the channel tag in plain binary, where value k means channel k.
- R3: A write whose channel number is 30 or higher (outside the NUM_CHAN=30 supported channels) still stores the result, but its tag field reads as 0.
- R4: When the queue is empty, rd_data reads as zero. A read strobe while empty does not move the read position: the next entry written is the next one read.
- R5: A write while four entries are held is dropped and sets ovr_flag. ovr_flag stays set until an ovr_clr pulse. If a dropped write and ovr_clr arrive in the same cycle, the set wins.
- R6: The threshold register resets to 0 and is loaded from thr_wdata when thr_we is high. Code n means n+1 entries, so codes 0 to 3 select 1 to 4 entries.
- R7: irq_flag goes high on the clock edge at which the fill level reaches the threshold (it is visible after that edge). It stays high until an irq_clr pulse.
- R8: After a clear while the fill level still meets the threshold, irq_flag stays low. It rises again only after the level has dropped below the threshold and then reached it again.
- R9: After reset, the queue is empty, rd_data is zero, and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Conversion-complete write strobe |
| wr_result | input | 12 | Conversion result |
| wr_chan | input | 5 | Channel number of the result |
| rd_en | input | 1 | Read strobe; pops the oldest entry at the clock edge |
| rd_data | output | 32 | Oldest entry, formatted as a read word (combinational) |
| thr_we | input | 1 | Threshold register write enable |
| thr_wdata | input | 2 | New threshold code |
| irq_flag | output | 1 | Threshold interrupt request flag |
| irq_clr | input | 1 | Write-one-to-clear for irq_flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Write-one-to-clear for ovr_flag |

## Verification
The ordering and format checks use three input patterns.
- Four writes followed by four reads. This shows whether the read side really walks all four stages in write order.
- Interleaved writes and reads. These wrap the pointers and expose an off-by-one pointer or a stale head.
- Results with distinct high and low bit patterns, paired with tags at channel 0, channel 29 and the unsupported codes 30 and 31. These separate a swapped or shifted field from correct packing, and show whether unsupported tags are suppressed.

The threshold runs compare code 0 with code 3 to tell the n+1 mapping from a plain n. The clear-then-refill sequence tells a level-triggered flag apart from one that fires only on a fresh crossing.

// File: rtl/cq_pkg.sv
package cq_pkg;
    localparam int RES_W    = 12;
    localparam int TAG_W    = 5;
    localparam int WORD_W   = 32;
    localparam int PAD_W    = WORD_W - RES_W - TAG_W;
    localparam int THR_W    = 2;
    localparam int DEPTH    = 4;
    localparam int NUM_CHAN = 30;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [TAG_W-1:0] tag;
    } cq_entry_t;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } fill_st_e;

    typedef enum logic [1:0] {
        I_WAIT   = 2'd0,
        I_RAISED = 2'd1,
        I_SPENT  = 2'd2
    } irq_st_e;
endpackage

// File: rtl/cq_fill_fsm.sv
module cq_fill_fsm
    import cq_pkg::*;
#(
    parameter int Q_DEPTH = DEPTH,
    parameter int CW      = $clog2(Q_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          ovr_clr,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          empty,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_nx,
    output logic          ovr_flag
);
    localparam logic [CW-1:0] CNT_FULL = CW'(Q_DEPTH);

    fill_st_e st_q, st_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= Q_EMPTY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    // next-state and outputs
    always_comb begin
        push_ok = wr_en && (st_q != Q_FULL);
        pop_ok  = rd_en && (st_q != Q_EMPTY);
        empty   = (st_q == Q_EMPTY);
        cnt_nx  = cnt_q + CW'(push_ok) - CW'(pop_ok);
        st_nx   = st_q;
        unique case (st_q)
            Q_EMPTY: begin
                // fill
                if (push_ok) st_nx = (cnt_nx == CNT_FULL) ? Q_FULL : Q_PART;
            end
            Q_PART: begin
                // top-off / drain
                if (cnt_nx == CNT_FULL)  st_nx = Q_FULL;
                else if (cnt_nx == '0)   st_nx = Q_EMPTY;
            end
            Q_FULL: begin
                // release
                if (pop_ok) st_nx = (cnt_nx == '0) ? Q_EMPTY : Q_PART;
            end
            default: st_nx = Q_EMPTY;
        endcase
    end

    // sticky overrun: a dropped write outranks a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ovr_flag <= 1'b0;
        else if (wr_en && st_q == Q_FULL)    ovr_flag <= 1'b1;
        else if (ovr_clr)                    ovr_flag <= 1'b0;
    end
endmodule

// File: rtl/cq_store.sv
module cq_store
    import cq_pkg::*;
#(
    parameter int Q_DEPTH = DEPTH,
    parameter int N_CHAN  = NUM_CHAN,
    localparam int AW     = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              empty,
    input  logic [RES_W-1:0]  wr_result,
    input  logic [TAG_W-1:0]  wr_chan,
    output logic [WORD_W-1:0] rd_word
);
    localparam logic [TAG_W-1:0] CH_LIMIT = TAG_W'(N_CHAN);
    localparam logic [AW-1:0]    LAST     = AW'(Q_DEPTH - 1);

    cq_entry_t       stage [Q_DEPTH];
    cq_entry_t       incoming;
    cq_entry_t       head;
    logic [AW-1:0]   wp, rp;

    always_comb begin
        incoming.res = wr_result;
        incoming.tag = (wr_chan < CH_LIMIT) ? wr_chan : '0;
    end

    for (genvar i = 0; i < Q_DEPTH; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           stage[i] <= '0;
            else if (push && wp == AW'(i))        stage[i] <= incoming;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= (wp == LAST) ? '0 : wp + AW'(1);
            if (pop)  rp <= (rp == LAST) ? '0 : rp + AW'(1);
        end
    end

    assign head    = stage[rp];
    assign rd_word = empty ? '0 : {head.res, {PAD_W{1'b0}}, head.tag};
endmodule

// File: rtl/cq_irq_fsm.sv
module cq_irq_fsm #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_nx,
    input  logic [CW-1:0] need,
    input  logic          irq_clr,
    output logic          irq_flag
);
    import cq_pkg::*;

    irq_st_e st_q, st_nx;
    logic    met;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= I_WAIT;
        else        st_q <= st_nx;
    end

    always_comb begin
        met   = (cnt_nx >= need);
        st_nx = st_q;
        unique case (st_q)
            I_WAIT:   if (met) st_nx = I_RAISED;                      // raise
            I_RAISED: if (irq_clr) st_nx = met ? I_SPENT : I_WAIT;    // ack-high / ack-low
            I_SPENT:  if (!met) st_nx = I_WAIT;                       // rearm
            default:  st_nx = I_WAIT;
        endcase
    end

    // output process
    always_comb begin
        irq_flag = (st_q == I_RAISED);
    end
endmodule

// File: rtl/conv_result_queue.sv
module conv_result_queue
    import cq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RES_W-1:0]  wr_result,
    input  logic [TAG_W-1:0]  wr_chan,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              thr_we,
    input  logic [THR_W-1:0]  thr_wdata,
    output logic              irq_flag,
    input  logic              irq_clr,
    output logic              ovr_flag,
    input  logic              ovr_clr
);
    localparam int CW = $clog2(DEPTH + 1);

    logic             push_ok, pop_ok, empty;
    logic [CW-1:0]    fill_cnt, fill_nx, need;
    logic [THR_W-1:0] thr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      thr_q <= '0;
        else if (thr_we) thr_q <= thr_wdata;
    end

    assign need = CW'(thr_q) + CW'(1);

    cq_fill_fsm #(.Q_DEPTH(DEPTH), .CW(CW)) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .ovr_clr  (ovr_clr),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .empty    (empty),
        .cnt_q    (fill_cnt),
        .cnt_nx   (fill_nx),
        .ovr_flag (ovr_flag)
    );

    cq_store #(.Q_DEPTH(DEPTH), .N_CHAN(NUM_CHAN)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_ok),
        .pop       (pop_ok),
        .empty     (empty),
        .wr_result (wr_result),
        .wr_chan   (wr_chan),
        .rd_word   (rd_data)
    );

    cq_irq_fsm #(.CW(CW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_nx   (fill_nx),
        .need     (need),
        .irq_clr  (irq_clr),
        .irq_flag (irq_flag)
    );
endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
    parameter int CW = 3,
    parameter int QD = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [31:0]   rd_data,
    input logic          thr_we,
    input logic          irq_flag,
    input logic          irq_clr,
    input logic          ovr_flag,
    input logic          ovr_clr,
    input logic [CW-1:0] fill_cnt,
    input logic [CW-1:0] need
);
    // R1
    cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(QD));

    // R2
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[19:5] == 15'd0);

    // R4
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt == '0 |-> rd_data == 32'd0);

    // R4
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == '0 && rd_en && !wr_en) |=> fill_cnt == '0);

    // R5
    full_write_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == CW'(QD) && wr_en) |=> ovr_flag);

    // R5
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R8
    no_reraise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && irq_clr && fill_cnt >= need && !rd_en && !thr_we) |=> !irq_flag);
endmodule

bind conv_result_queue cq_checker #(.CW(CW), .QD(cq_pkg::DEPTH)) u_cq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .thr_we   (thr_we),
    .irq_flag (irq_flag),
    .irq_clr  (irq_clr),
    .ovr_flag (ovr_flag),
    .ovr_clr  (ovr_clr),
    .fill_cnt (fill_cnt),
    .need     (need)
);

// File: tb/test_conv_result_queue.sv
`timescale 1ns/1ps
module test_conv_result_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_result = '0;
    logic [4:0]  wr_chan = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        thr_we = 1'b0;
    logic [1:0]  thr_wdata = '0;
    logic        irq_flag;
    logic        irq_clr = 1'b0;
    logic        ovr_flag;
    logic        ovr_clr = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    conv_result_queue i_conv_result_queue (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_result(wr_result),
        .wr_chan(wr_chan), .rd_en(rd_en), .rd_data(rd_data),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .irq_flag(irq_flag),
        .irq_clr(irq_clr), .ovr_flag(ovr_flag), .ovr_clr(ovr_clr)
    );

    typedef struct packed {
        logic        rd;
        logic [11:0] res;
        logic [4:0]  ch;
        logic [31:0] exp;
    } vec_t;

    // write: {0,res,ch,-}; read: {1,-,-,expected word}
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        {1'b0, 12'hA11, 5'd0,  32'h0},
        {1'b0, 12'h5C3, 5'd29, 32'h0},
        {1'b0, 12'hFFF, 5'd30, 32'h0},
        {1'b0, 12'h001, 5'd7,  32'h0},
        {1'b1, 12'h0,   5'd0,  32'hA110_0000},
        {1'b1, 12'h0,   5'd0,  32'h5C30_001D},
        {1'b1, 12'h0,   5'd0,  32'hFFF0_0000},
        {1'b1, 12'h0,   5'd0,  32'h0010_0007},
        {1'b0, 12'h800, 5'd16, 32'h0},
        {1'b0, 12'h7FE, 5'd31, 32'h0},
        {1'b1, 12'h0,   5'd0,  32'h8000_0010},
        {1'b0, 12'h3A5, 5'd3,  32'h0},
        {1'b1, 12'h0,   5'd0,  32'h7FE0_0000},
        {1'b1, 12'h0,   5'd0,  32'h3A50_0003}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [11:0] r, input logic [4:0] c);
        @(negedge clk);
        wr_en = 1'b1; wr_result = r; wr_chan = c;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // samples the head word just before the popping edge
    task automatic do_read(input string req, input logic [31:0] exp);
        @(negedge clk);
        rd_en = 1'b1;
        #1 check(req, rd_data, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_thr(input logic [1:0] code);
        @(negedge clk);
        thr_we = 1'b1; thr_wdata = code;
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    task automatic pulse_irq_clr();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R9 reset state
        check("R9 rd_data", rd_data, 32'h0);
        check("R9 irq", {31'd0, irq_flag}, 32'd0);
        check("R9 ovr", {31'd0, ovr_flag}, 32'd0);

        // R1 R2 R3 vector walk (threshold left at reset value)
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) do_read("R1/R2/R3 vector", VECS[i].exp);
            else            do_write(VECS[i].res, VECS[i].ch);
        end

        // R4 empty read returns zero and does not move the pointer
        do_read("R4 empty read", 32'h0);
        do_read("R4 empty read again", 32'h0);
        do_write(12'h123, 5'd5);
        do_read("R4 pointer held", 32'h1230_0005);

        // R6 reset threshold code 0 means one entry
        do_reset();
        do_write(12'h111, 5'd1);
        check("R6 code0 one entry", {31'd0, irq_flag}, 32'd1);

        // R6 code 3 means four entries
        do_reset();
        set_thr(2'd3);
        for (int k = 0; k < 3; k++) do_write(12'h200 + 12'(k), 5'(k));
        check("R6 code3 three held", {31'd0, irq_flag}, 32'd0);
        do_write(12'h2FF, 5'd9);
        check("R6 code3 four held", {31'd0, irq_flag}, 32'd1);

        // R7 R8 threshold code 2 = three entries
        do_reset();
        set_thr(2'd2);
        do_write(12'h301, 5'd1);
        do_write(12'h302, 5'd2);
        check("R7 below threshold", {31'd0, irq_flag}, 32'd0);
        do_write(12'h303, 5'd3);
        check("R7 raised", {31'd0, irq_flag}, 32'd1);
        repeat (3) @(negedge clk);
        check("R7 sticky", {31'd0, irq_flag}, 32'd1);
        pulse_irq_clr();
        check("R8 cleared while met", {31'd0, irq_flag}, 32'd0);
        do_write(12'h304, 5'd4);
        check("R8 no reraise at four", {31'd0, irq_flag}, 32'd0);
        do_read("R1 order after irq", 32'h3010_0001);
        do_read("R1 order after irq", 32'h3020_0002);
        check("R8 below threshold", {31'd0, irq_flag}, 32'd0);
        do_write(12'h305, 5'd5);
        check("R8 reraise on new crossing", {31'd0, irq_flag}, 32'd1);

        // R5 overrun
        do_reset();
        for (int k = 0; k < 4; k++) do_write(12'h400 + 12'(k), 5'(k + 10));
        check("R5 no overrun at four", {31'd0, ovr_flag}, 32'd0);
        do_write(12'hBAD, 5'd20);
        check("R5 overrun set", {31'd0, ovr_flag}, 32'd1);
        for (int k = 0; k < 4; k++)
            do_read("R5 dropped write not stored",
                    {12'h400 + 12'(k), 15'd0, 5'(k + 10)});
        do_read("R5 empty after drain", 32'h0);
        check("R5 sticky", {31'd0, ovr_flag}, 32'd1);
        @(negedge clk);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check("R5 cleared", {31'd0, ovr_flag}, 32'd0);

        finish_run();
    end
endmodule